// File: doc/BRIEF.md
# Master Address Window Mapper

This block sits on the master path between a local CPU and a VMEbus interface. For every master-access request it decides which bus address space and data width the cycle uses. It also produces the address to drive on the bus and the 6-bit address modifier code. Three windows are decoded: a 64 KB short-address window at the very top of the CPU map, and a pair of adjacent 16 MB standard-address windows.

The standard-address pair normally sits in the F8/F9 page. A control bit can move it down to page 0, which frees the high page for extended devices. Each window kind has its own disable bit. A disabled window, and any address outside every enabled window, decodes as extended 32-bit addressing with 32-bit data. For short-address and standard-address cycles the unused upper address bits are driven as ones.

The result is registered, so outputs appear one clock after the request together with a valid strobe. Bus arbitration, the data transfer and slave-side decoding happen elsewhere.

Top module: `mwm_master_mapper`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid`, `out_space`, `out_addr` and `out_am` all become zero.
- R2: `out_valid` equals the value `req_valid` had one clock earlier. No output changes in the same cycle as the request.
- R3: With `ctl_a16_off` low, a request in FFFF0000h–FFFFFFFFh gives `out_space` = 3 (A16, 16-bit data). `out_addr` then has bits 31–16 at one and bits 15–0 copied from the request.
- R4: With `ctl_a16_off` high, requests in FFFF0000h–FFFFFFFFh give `out_space` = 0 (A32:D32) and pass the address through unchanged.
- R5: With `ctl_a24_off` and `ctl_a24_low` low, F8000000h–F8FFFFFFh gives `out_space` = 1 (A24:D16) and F9000000h–F9FFFFFFh gives `out_space` = 2 (A24:D32).
- R6: With `ctl_a24_low` high and `ctl_a24_off` low, 00000000h–00FFFFFFh gives `out_space` = 1 and 01000000h–01FFFFFFh gives `out_space` = 2. The F8/F9 ranges then give `out_space` = 0.
- R7: With `ctl_a24_off` high, no request gives `out_space` 1 or 2, whatever `ctl_a24_low` is. Both candidate standard ranges give `out_space` = 0.
- R8: For `out_space` 1 or 2, `out_addr` bits 31–24 are one and bits 23–0 are copied from the request.
- R9: `out_am` is 2Dh for A16, 3Dh for A24 and 0Dh for A32 when `req_super` was high. With `req_super` low it is 29h, 39h and 09h respectively.
- R10: Any address outside all enabled windows gives `out_space` = 0 and `out_addr` equal to the request address.
- R11: A clock edge with `req_valid` low leaves `out_space`, `out_addr` and `out_am` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe for the current CPU address |
| req_addr | input | 32 | CPU address of the master access |
| req_super | input | 1 | 1 = supervisor access, 0 = user access |
| ctl_a16_off | input | 1 | Disable the short-address window |
| ctl_a24_off | input | 1 | Disable both standard-address windows |
| ctl_a24_low | input | 1 | Move the standard-address windows to page 0 |
| out_valid | output | 1 | Decoded result valid |
| out_space | output | 2 | 0 A32:D32, 1 A24:D16, 2 A24:D32, 3 A16:D16 |
| out_addr | output | 32 | Address to drive on the bus |
| out_am | output | 6 | Address modifier code |

## Verification
The assertions check these properties on every cycle:
- the one-cycle valid latency;
- the forced-ones upper bits for short and standard cycles;
- the modifier's space bits and supervisor bit;
- that a disable bit removes its window;
- address pass-through for extended cycles;
- holding when no request is present.

Some properties depend on where the window edges lie, and only the directed scenarios can show them:
- each window's exact boundary addresses in the default and relocated layouts;
- the precedence of disable over relocation;
- the reset values.

// File: rtl/mwm_pkg.sv
// Shared types and constants for the master address window mapper.
package mwm_pkg;

    // Space/width code carried on out_space.
    typedef enum logic [1:0] {
        SPC_A32D32 = 2'd0,
        SPC_A24D16 = 2'd1,
        SPC_A24D32 = 2'd2,
        SPC_A16D16 = 2'd3
    } space_e;

    // Upper three modifier bits per address space; bit 2 is the privilege bit.
    localparam logic [2:0] AM_TOP_A16 = 3'b101;
    localparam logic [2:0] AM_TOP_A24 = 3'b111;
    localparam logic [2:0] AM_TOP_A32 = 3'b001;
    localparam logic [1:0] AM_LOW_DATA = 2'b01;

endpackage

// File: rtl/mwm_window_decode.sv
// Window decoder: classifies a CPU address into a bus space.
// Assumes the short window occupies the top 2**SHORT_W bytes.
// Assumes the standard windows form an aligned pair of 2**STD_W-byte blocks
// whose base page is chosen by the relocation bit.
// Purely combinational.
module mwm_window_decode
    import mwm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SHORT_W = 16,
    parameter int STD_W = 24,
    parameter logic [ADDR_W-STD_W-1:0] STD_HIGH_PAGE = 8'hF8,
    parameter logic [ADDR_W-STD_W-1:0] STD_LOW_PAGE = 8'h00
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              a16_off,
    input  logic              a24_off,
    input  logic              a24_low,
    output space_e            space
);
    localparam int SHORT_TAG_W = ADDR_W - SHORT_W;
    localparam int PAIR_TAG_W = ADDR_W - STD_W - 1;

    logic [PAIR_TAG_W-1:0] pair_tag;
    logic                  short_hit;
    logic                  pair_hit;

    // Select which page pair the standard windows occupy.
    always_comb begin
        pair_tag = a24_low ? STD_LOW_PAGE[ADDR_W-STD_W-1:1]
                           : STD_HIGH_PAGE[ADDR_W-STD_W-1:1];
    end

    // Window hits, each gated by its disable bit.
    always_comb begin
        short_hit = !a16_off && (addr[ADDR_W-1:SHORT_W] == {SHORT_TAG_W{1'b1}});
        pair_hit  = !a24_off && (addr[ADDR_W-1:STD_W+1] == pair_tag);
    end

    // Resolve the space; the lower block of the pair is the 16-bit data window.
    always_comb begin
        if (short_hit) begin
            space = SPC_A16D16;
        end else if (pair_hit) begin
            space = addr[STD_W] ? SPC_A24D32 : SPC_A24D16;
        end else begin
            space = SPC_A32D32;
        end
    end

endmodule

// File: rtl/mwm_addr_form.sv
// Address and modifier former: drives the upper bits that a narrow space
// does not use as ones, and builds the modifier from space and privilege.
// Purely combinational.
module mwm_addr_form
    import mwm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SHORT_W = 16,
    parameter int STD_W = 24,
    parameter int AM_W = 6
) (
    input  space_e            space,
    input  logic [ADDR_W-1:0] addr,
    input  logic              super_acc,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [AM_W-1:0]   am
);
    logic is_short;
    logic is_std;

    // Space class flags.
    always_comb begin
        is_short = (space == SPC_A16D16);
        is_std   = (space == SPC_A24D16) || (space == SPC_A24D32);
    end

    // Per-bit forcing: bits above the space's width are driven as ones.
    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        if (i >= STD_W) begin : g_above_std
            assign bus_addr[i] = addr[i] | is_short | is_std;
        end else if (i >= SHORT_W) begin : g_above_short
            assign bus_addr[i] = addr[i] | is_short;
        end else begin : g_pass
            assign bus_addr[i] = addr[i];
        end
    end

    // Modifier: space bits, privilege bit, data-access bits.
    always_comb begin
        unique case (space)
            SPC_A16D16: am = {AM_TOP_A16, super_acc, AM_LOW_DATA};
            SPC_A24D16,
            SPC_A24D32: am = {AM_TOP_A24, super_acc, AM_LOW_DATA};
            default:    am = {AM_TOP_A32, super_acc, AM_LOW_DATA};
        endcase
    end

endmodule

// File: rtl/mwm_master_mapper.sv
// Master address window mapper top.
// Decodes each valid request into space, bus address and modifier.
// Registers the result with one cycle of latency.
// Assumes the control bits are stable while a request is presented.
// Synchronous active-low reset.
module mwm_master_mapper
    import mwm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SHORT_W = 16,
    parameter int STD_W = 24,
    parameter int AM_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_super,
    input  logic              ctl_a16_off,
    input  logic              ctl_a24_off,
    input  logic              ctl_a24_low,
    output logic              out_valid,
    output logic [1:0]        out_space,
    output logic [ADDR_W-1:0] out_addr,
    output logic [AM_W-1:0]   out_am
);
    space_e            dec_space;
    logic [ADDR_W-1:0] dec_addr;
    logic [AM_W-1:0]   dec_am;

    mwm_window_decode #(
        .ADDR_W (ADDR_W),
        .SHORT_W(SHORT_W),
        .STD_W  (STD_W)
    ) u_decode (
        .addr   (req_addr),
        .a16_off(ctl_a16_off),
        .a24_off(ctl_a24_off),
        .a24_low(ctl_a24_low),
        .space  (dec_space)
    );

    mwm_addr_form #(
        .ADDR_W (ADDR_W),
        .SHORT_W(SHORT_W),
        .STD_W  (STD_W),
        .AM_W   (AM_W)
    ) u_form (
        .space    (dec_space),
        .addr     (req_addr),
        .super_acc(req_super),
        .bus_addr (dec_addr),
        .am       (dec_am)
    );

    // Valid strobe follows the request by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= req_valid;
        end
    end

    // Result registers load only when a request is present.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_space <= '0;
            out_addr  <= '0;
            out_am    <= '0;
        end else if (req_valid) begin
            out_space <= dec_space;
            out_addr  <= dec_addr;
            out_am    <= dec_am;
        end
    end

endmodule

// File: rtl/mwm_checker.sv
// Protocol checker for mwm_master_mapper, attached by bind.
// Assumes the default 32-bit address and 6-bit modifier widths.
module mwm_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [31:0] req_addr,
    input logic        req_super,
    input logic        ctl_a16_off,
    input logic        ctl_a24_off,
    input logic        out_valid,
    input logic [1:0]  out_space,
    input logic [31:0] out_addr,
    input logic [5:0]  out_am
);
    p_valid_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);
    p_valid_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid);
    p_short_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_space == 2'd3) |-> out_addr[31:16] == 16'hFFFF);
    p_short_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ctl_a16_off) |=> out_space != 2'd3);
    p_std_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ctl_a24_off) |=> (out_space == 2'd0 || out_space == 2'd3));
    p_std_ones_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (out_space == 2'd1 || out_space == 2'd2)) |-> out_addr[31:24] == 8'hFF);
    p_std_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid ##1 (out_space == 2'd1 || out_space == 2'd2)) |-> out_addr[23:0] == $past(req_addr[23:0]));
    p_am_priv_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_am[2] == $past(req_super));
    p_am_space_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_am[1:0] == 2'b01) &&
                      (out_space == 2'd3 ? out_am[5:3] == 3'b101 :
                       out_space == 2'd0 ? out_am[5:3] == 3'b001 :
                                           out_am[5:3] == 3'b111));
    p_a32_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid ##1 out_space == 2'd0) |-> out_addr == $past(req_addr));
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(out_space) && $stable(out_addr) && $stable(out_am)));

endmodule

bind mwm_master_mapper mwm_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_super  (req_super),
    .ctl_a16_off(ctl_a16_off),
    .ctl_a24_off(ctl_a24_off),
    .out_valid  (out_valid),
    .out_space  (out_space),
    .out_addr   (out_addr),
    .out_am     (out_am)
);

// File: tb/sim_mwm_master_mapper.sv
// Directed bench for mwm_master_mapper: one task per scenario.
module sim_mwm_master_mapper;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_super = 1'b0;
    logic        ctl_a16_off = 1'b0;
    logic        ctl_a24_off = 1'b0;
    logic        ctl_a24_low = 1'b0;
    logic        out_valid;
    logic [1:0]  out_space;
    logic [31:0] out_addr;
    logic [5:0]  out_am;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    mwm_master_mapper u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_super(req_super), .ctl_a16_off(ctl_a16_off), .ctl_a24_off(ctl_a24_off),
        .ctl_a24_low(ctl_a24_low), .out_valid(out_valid), .out_space(out_space),
        .out_addr(out_addr), .out_am(out_am)
    );

    // Record one comparison.
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // Expected space code from the requirement ranges.
    function automatic logic [1:0] exp_space(input logic [31:0] a);
        if (!ctl_a16_off && a >= 32'hFFFF0000) return 2'd3;
        if (!ctl_a24_off && !ctl_a24_low) begin
            if (a >= 32'hF8000000 && a <= 32'hF8FFFFFF) return 2'd1;
            if (a >= 32'hF9000000 && a <= 32'hF9FFFFFF) return 2'd2;
        end
        if (!ctl_a24_off && ctl_a24_low) begin
            if (a <= 32'h00FFFFFF) return 2'd1;
            if (a >= 32'h01000000 && a <= 32'h01FFFFFF) return 2'd2;
        end
        return 2'd0;
    endfunction

    // Expected bus address for a given space.
    function automatic logic [31:0] exp_addr(input logic [1:0] s, input logic [31:0] a);
        case (s)
            2'd3:       return {16'hFFFF, a[15:0]};
            2'd1, 2'd2: return {8'hFF, a[23:0]};
            default:    return a;
        endcase
    endfunction

    // Expected modifier for a given space and privilege.
    function automatic logic [5:0] exp_am(input logic [1:0] s, input logic sup);
        case (s)
            2'd3:       return sup ? 6'h2D : 6'h29;
            2'd1, 2'd2: return sup ? 6'h3D : 6'h39;
            default:    return sup ? 6'h0D : 6'h09;
        endcase
    endfunction

    // Issue one request and check the registered result.
    task automatic do_req(input string tag, input logic [31:0] a, input logic sup);
        logic [1:0] s;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr = a;
        req_super = sup;
        s = exp_space(a);
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " R2 valid"}, 32'(out_valid), 32'd1);
        chk({tag, " space"}, 32'(out_space), 32'(s));
        chk({tag, " addr"}, out_addr, exp_addr(s, a));
        chk({tag, " R9 am"}, 32'(out_am), 32'(exp_am(s, sup)));
    endtask

    task automatic set_ctl(input logic a16off, input logic a24off, input logic low);
        @(negedge clk);
        ctl_a16_off = a16off;
        ctl_a24_off = a24off;
        ctl_a24_low = low;
    endtask

    // R1: reset values.
    task automatic t_reset();
        rst_n = 1'b0;
        req_valid = 1'b1;
        req_addr = 32'hFFFF1234;
        repeat (3) @(negedge clk);
        chk("R1 valid", 32'(out_valid), 32'd0);
        chk("R1 space", 32'(out_space), 32'd0);
        chk("R1 addr", out_addr, 32'd0);
        chk("R1 am", 32'(out_am), 32'd0);
        req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // R2: no same-cycle response, one-cycle latency, strobe drops after.
    task automatic t_latency();
        @(negedge clk);
        req_valid = 1'b1;
        req_addr = 32'h12345678;
        #1;
        chk("R2 no comb path", 32'(out_valid), 32'd0);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2 one cycle", 32'(out_valid), 32'd1);
        @(negedge clk);
        chk("R2 drop", 32'(out_valid), 32'd0);
    endtask

    // R3 and R9: short window enabled, both privilege levels, edges.
    task automatic t_short();
        set_ctl(1'b0, 1'b0, 1'b0);
        do_req("R3 lo edge", 32'hFFFF0000, 1'b1);
        do_req("R3 hi edge", 32'hFFFFFFFF, 1'b0);
        do_req("R3 mid", 32'hFFFFA5C3, 1'b1);
        do_req("R10 below short", 32'hFFFEFFFF, 1'b1);
    endtask

    // R4: short window disabled.
    task automatic t_short_off();
        set_ctl(1'b1, 1'b0, 1'b0);
        do_req("R4 off", 32'hFFFF8000, 1'b1);
        do_req("R4 off user", 32'hFFFFFFFF, 1'b0);
    endtask

    // R5 and R8: default standard windows and their edges.
    task automatic t_std_default();
        set_ctl(1'b0, 1'b0, 1'b0);
        do_req("R5 d16 lo", 32'hF8000000, 1'b1);
        do_req("R5 d16 hi", 32'hF8FFFFFF, 1'b0);
        do_req("R5 d32 lo", 32'hF9000000, 1'b1);
        do_req("R5 d32 hi", 32'hF9FFFFFF, 1'b0);
        do_req("R10 below", 32'hF7FFFFFF, 1'b1);
        do_req("R10 above", 32'hFA000000, 1'b1);
        do_req("R10 page0", 32'h00123456, 1'b0);
    endtask

    // R6 and R8: relocated windows, upper bits forced.
    task automatic t_std_low();
        set_ctl(1'b0, 1'b0, 1'b1);
        do_req("R6 d16 lo", 32'h00000000, 1'b1);
        do_req("R6 d16 hi", 32'h00FFFFFF, 1'b0);
        do_req("R6 d32 lo", 32'h01000000, 1'b1);
        do_req("R8 d32 hi", 32'h01ABCDEF, 1'b1);
        do_req("R6 past", 32'h02000000, 1'b1);
        do_req("R6 old F8", 32'hF8123456, 1'b1);
        do_req("R6 old F9", 32'hF9FEDCBA, 1'b0);
    endtask

    // R7: disable wins over relocation.
    task automatic t_std_off();
        set_ctl(1'b0, 1'b1, 1'b0);
        do_req("R7 F8", 32'hF8000010, 1'b1);
        do_req("R7 F9", 32'hF9000010, 1'b0);
        set_ctl(1'b0, 1'b1, 1'b1);
        do_req("R7 rel 00", 32'h00000010, 1'b1);
        do_req("R7 rel 01", 32'h01000010, 1'b1);
        do_req("R7 rel F9", 32'hF9000010, 1'b1);
        do_req("R7 short kept", 32'hFFFF0010, 1'b1);
    endtask

    // R11: idle cycles with changing inputs leave the outputs alone.
    task automatic t_hold();
        set_ctl(1'b0, 1'b0, 1'b0);
        do_req("R11 setup", 32'hF9001234, 1'b1);
        req_addr = 32'h00000042;
        req_super = 1'b0;
        ctl_a24_off = 1'b1;
        repeat (3) @(negedge clk);
        chk("R11 valid", 32'(out_valid), 32'd0);
        chk("R11 space", 32'(out_space), 32'd2);
        chk("R11 addr", out_addr, 32'hFF001234);
        chk("R11 am", 32'(out_am), 32'h3D);
    endtask

    initial begin
        t_reset();
        t_latency();
        t_short();
        t_short_off();
        t_std_default();
        t_std_low();
        t_std_off();
        t_hold();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule